// File: doc/BRIEF.md
# PWM Fault Protection Input Unit

This block watches an external fault pin and turns a chosen transition on it into a fault event. The event shuts down a PWM stage. The raw pin first passes through a two-flop synchroniser. An optional noise filter can then be switched in, which passes a new level only once four samples in a row agree on it. An edge detector follows, and its polarity is selected by a control bit. The detected event sets a sticky fault flag. The flag drives an interrupt request, when interrupts are allowed, and a kill output that forces the PWM outputs to their inactive state.

All control inputs are plain level pins that come from a register elsewhere. Software clears the flag with a one-cycle clear pulse. The block carries no data stream, so there is no valid/ready handshake. Every output is a level.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset `fault_flag`, `fault_irq` and `pwm_kill` are all 0.
- R2: With the filter off (`filt_en`=0), a qualifying pin transition driven between two clock edges sets `fault_flag`, and the flag is visible after the third rising edge that follows.
- R3: With the filter on (`filt_en`=1), the same transition sets `fault_flag` four cycles later than in R2, which is after the seventh rising edge.
- R4: With the filter on, a pin pulse shorter than four clock cycles produces no fault. A pulse held for four cycles produces one.
- R5: `edge_rise`=0 selects the falling edge (1 to 0) of the pin as the trigger, and `edge_rise`=1 selects the rising edge (0 to 1). The opposite edge never sets the flag.
- R6: While `prot_en`=0 no transition sets `fault_flag`.
- R7: `fault_irq` is 1 exactly when `fault_flag` is 1 and `irq_en` is 1.
- R8: A one-cycle `flag_clr`=1 clears `fault_flag` at the next edge. If a fault event happens in the same cycle, the set wins and the flag stays 1.
- R9: `pwm_kill` is 1 exactly when `fault_flag` is 1 and `prot_en` is 1.
- R10: Once set, `fault_flag` stays 1 until it is cleared, whatever the pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_pin | input | 1 | Raw, asynchronous fault pin |
| prot_en | input | 1 | Fault protection enable |
| filt_en | input | 1 | Four-sample noise filter enable |
| edge_rise | input | 1 | 1 = rising-edge trigger, 0 = falling-edge trigger |
| irq_en | input | 1 | Fault interrupt enable |
| flag_clr | input | 1 | One-cycle pulse that clears the fault flag |
| fault_flag | output | 1 | Sticky fault flag |
| fault_irq | output | 1 | Interrupt request level |
| pwm_kill | output | 1 | Forces the PWM outputs to their inactive state |

## Verification
The hardest case to reach from the ports is a fault event that lands in the same cycle as a clear pulse. The pin edge must be placed exactly three edges ahead (seven with the filter on) so that the detector fires while `flag_clr` is high. The bench builds this case with a directed sequence that counts edges from the pin change. It also builds the filter boundary, a pulse of three cycles against one of four. Long random runs then mix clears, polarity changes and filter switching against a cycle-level bench model.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned FILT_TAPS   = 4;

  typedef enum logic { EDGE_FALL = 1'b0, EDGE_RISE = 1'b1 } edge_sel_e;
endpackage

// File: rtl/fpg_sync.sv
module fpg_sync #(
  parameter int unsigned STAGES = fpg_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fpg_filter.sv
module fpg_filter #(
  parameter int unsigned TAPS = fpg_pkg::FILT_TAPS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [TAPS-1:0] hist;
  logic            held;
  logic            agree_hi, agree_lo;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hist <= '0;
    else        hist <= {hist[TAPS-2:0], d};

  assign agree_hi = &hist;
  assign agree_lo = ~|hist;

  always_comb begin
    if (agree_hi)      q = 1'b1;
    else if (agree_lo) q = 1'b0;
    else               q = held;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) held <= 1'b0;
    else        held <= q;
endmodule

// File: rtl/fpg_edge.sv
module fpg_edge
  import fpg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sig,
  input  edge_sel_e pol,
  input  logic      arm,
  output logic      evt
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= sig;

  always_comb begin
    unique case (pol)
      EDGE_RISE: evt = arm &  sig & ~prev;
      default:   evt = arm & ~sig &  prev;
    endcase
  end
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import fpg_pkg::*;
#(
  parameter int unsigned SYNC_N = SYNC_STAGES,
  parameter int unsigned TAPS   = FILT_TAPS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_pin,
  input  logic prot_en,
  input  logic filt_en,
  input  logic edge_rise,
  input  logic irq_en,
  input  logic flag_clr,
  output logic fault_flag,
  output logic fault_irq,
  output logic pwm_kill
);
  logic pin_sync;
  logic pin_filt;
  logic det_in;
  logic fault_evt;
  edge_sel_e pol;

  fpg_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(fault_pin), .q(pin_sync)
  );

  fpg_filter #(.TAPS(TAPS)) u_filt (
    .clk(clk), .rst_n(rst_n), .d(pin_sync), .q(pin_filt)
  );

  assign det_in = filt_en ? pin_filt : pin_sync;
  assign pol    = edge_sel_e'(edge_rise);

  fpg_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sig(det_in), .pol(pol),
    .arm(prot_en), .evt(fault_evt)
  );

  // set has priority over software clear
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         fault_flag <= 1'b0;
    else if (fault_evt) fault_flag <= 1'b1;
    else if (flag_clr)  fault_flag <= 1'b0;

  assign fault_irq = fault_flag & irq_en;
  assign pwm_kill  = fault_flag & prot_en;
endmodule

// File: rtl/pwm_fault_guard_chk.sv
module pwm_fault_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic prot_en,
  input logic irq_en,
  input logic flag_clr,
  input logic fault_evt,
  input logic fault_flag,
  input logic fault_irq,
  input logic pwm_kill
);
  // R6
  set_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flag) |-> $past(prot_en));

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fault_flag) && !$past(flag_clr)) |-> fault_flag);

  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_clr) && !$past(fault_evt)) |-> !fault_flag);

  // R7
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |-> (irq_en && fault_flag));

  // R9
  kill_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_kill |-> (prot_en && fault_flag));
endmodule

bind pwm_fault_guard pwm_fault_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .irq_en(irq_en),
  .flag_clr(flag_clr), .fault_evt(fault_evt), .fault_flag(fault_flag),
  .fault_irq(fault_irq), .pwm_kill(pwm_kill)
);

// File: tb/tb_pwm_fault_guard.sv
module tb_pwm_fault_guard;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault_pin = 1'b0, prot_en = 1'b0, filt_en = 1'b0;
  logic edge_rise = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
  logic fault_flag, fault_irq, pwm_kill;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  bit cmp_model = 1'b0;

  // bench model state
  logic m_s1, m_s2, m_held, m_prev, m_flag;
  logic [3:0] m_h;

  always #(CLK_P/2) clk = ~clk;

  pwm_fault_guard dut (
    .clk(clk), .rst_n(rst_n), .fault_pin(fault_pin), .prot_en(prot_en),
    .filt_en(filt_en), .edge_rise(edge_rise), .irq_en(irq_en),
    .flag_clr(flag_clr), .fault_flag(fault_flag), .fault_irq(fault_irq),
    .pwm_kill(pwm_kill)
  );

  task automatic check(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic mdl_filt();
    if (&m_h) return 1'b1;
    if (~|m_h) return 1'b0;
    return m_held;
  endfunction

  function automatic logic mdl_sel();
    return filt_en ? mdl_filt() : m_s2;
  endfunction

  task automatic mdl_reset();
    m_s1 = 0; m_s2 = 0; m_held = 0; m_prev = 0; m_flag = 0; m_h = '0;
  endtask

  task automatic mdl_tick();
    logic f, s, ev;
    f = mdl_filt();
    s = mdl_sel();
    ev = prot_en && (edge_rise ? (s && !m_prev) : (!s && m_prev));
    if (ev) m_flag = 1'b1;
    else if (flag_clr) m_flag = 1'b0;
    m_prev = s;
    m_held = f;
    m_h = {m_h[2:0], m_s2};
    m_s2 = m_s1;
    m_s1 = fault_pin;
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      mdl_tick();
      #1;
      if (cmp_model) begin
        check("R10 flag vs model", fault_flag, m_flag);
        check("R7 irq vs model", fault_irq, m_flag & irq_en);
        check("R9 kill vs model", pwm_kill, m_flag & prot_en);
      end
      @(negedge clk);
    end
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
  endtask

  initial begin
    mdl_reset();
    @(negedge clk); @(negedge clk);
    #1;
    check("R1 flag after reset", fault_flag, 1'b0);
    check("R1 irq after reset", fault_irq, 1'b0);
    check("R1 kill after reset", pwm_kill, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R5: unfiltered, falling edge trigger
    prot_en = 1; edge_rise = 0; fault_pin = 1;
    cyc(6);
    check("R5 rising ignored under falling select", fault_flag, 1'b0);
    fault_pin = 0;
    cyc(2);
    check("R2 not yet after 2 edges", fault_flag, 1'b0);
    cyc(1);
    check("R2 set after 3 edges", fault_flag, 1'b1);

    // R10 sticky, R7 irq gating, R9 kill gating
    fault_pin = 1; cyc(6);
    check("R10 flag holds", fault_flag, 1'b1);
    check("R7 irq off when disabled", fault_irq, 1'b0);
    irq_en = 1; #1;
    check("R7 irq on", fault_irq, 1'b1);
    check("R9 kill on", pwm_kill, 1'b1);
    prot_en = 0; #1;
    check("R9 kill off with protection off", pwm_kill, 1'b0);
    prot_en = 1;
    @(negedge clk);

    // R8 clear
    clear_flag();
    check("R8 cleared", fault_flag, 1'b0);

    // R3 filtered latency, rising edge
    filt_en = 1; edge_rise = 1; fault_pin = 0;
    cyc(10);
    clear_flag();
    fault_pin = 1;
    cyc(6);
    check("R3 not yet after 6 edges", fault_flag, 1'b0);
    cyc(1);
    check("R3 set after 7 edges", fault_flag, 1'b1);

    // R4 pulse width filter
    fault_pin = 0; cyc(10); clear_flag();
    fault_pin = 1; cyc(3); fault_pin = 0; cyc(12);
    check("R4 3-cycle pulse rejected", fault_flag, 1'b0);
    fault_pin = 1; cyc(4); fault_pin = 0; cyc(12);
    check("R4 4-cycle pulse accepted", fault_flag, 1'b1);

    // R6 protection disabled
    filt_en = 0; clear_flag();
    prot_en = 0;
    fault_pin = 1; cyc(6); fault_pin = 0; cyc(6);
    check("R6 no set while disabled", fault_flag, 1'b0);
    prot_en = 1; cyc(4);
    check("R6 still clear after enable", fault_flag, 1'b0);

    // R8 set beats clear in same cycle (unfiltered rising edge)
    fault_pin = 1; cyc(3); fault_pin = 0; cyc(4);
    check("R8 precondition flag set", fault_flag, 1'b1);
    fault_pin = 1; cyc(2);
    flag_clr = 1; cyc(1); flag_clr = 0;
    check("R8 set wins over clear", fault_flag, 1'b1);
    clear_flag();
    check("R8 plain clear", fault_flag, 1'b0);

    // random phase against bench model
    cmp_model = 1;
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 3) == 0) fault_pin = ~fault_pin;
      flag_clr  = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 63) == 0) prot_en   = ~prot_en;
      if ($urandom_range(0, 127) == 0) filt_en  = ~filt_en;
      if ($urandom_range(0, 63) == 0) edge_rise = ~edge_rise;
      if ($urandom_range(0, 31) == 0) irq_en    = ~irq_en;
      cyc(1);
    end
    flag_clr = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule